// File: doc/BRIEF.md
# Speaker Tone Generator with Gated Square-Wave Counter

This block makes the one-bit drive for a small speaker. The tone comes from a 16-bit reloadable divide-by-N counter. The counter advances only on cycles where a clock-enable is asserted; that enable is nominally about 1.19318 MHz. The counter produces a square wave. That wave is ANDed with a software-controlled data bit to give the speaker output.

Software reaches the block through a byte-wide write port with a small address field:
- Address 0 takes the divisor, as two byte writes with the low byte first.
- Address 1 is a two-bit control register holding the counter gate and the speaker data enable.

The live counter output is visible at all times on a separate status byte.

Software has three ways to make a tone, and may use them together:
- toggle the data bit with the gate held low, since the counter output is then forced high;
- program a divisor and let the counter run;
- pulse the gate bit, where every rising edge restarts the period.

Top module: `spkr_tone_top`

## Requirements
- R1: After reset the gate and data bits are 0 and the divisor is 65536. The speaker output is 0 and the status byte reads 0x20.
- R2: A write to address 1 sets the gate from data bit 0 and the speaker data enable from data bit 1. Writes to addresses 2 and 3 change nothing.
- R3: Writes to address 0 alternate between the low byte and the high byte, starting with the low byte. The divisor takes its new value on the high-byte write. A divisor of 0 means 65536.
- R4: With the gate high and a divisor N, the counter output repeats every N enable ticks. It is high for the first ceil(N/2) ticks of each period and low for the remaining floor(N/2).
- R5: While the gate is low, the counter output is forced high.
- R6: A control write that takes the gate from 0 to 1 reloads the divisor. The period restarts with the output high.
- R7: A divisor written while the counter runs does not change the current period. It takes effect at the next reload, which is either the end of the period or a rising gate edge.
- R8: In a cycle where the clock-enable is low, the counter does not advance.
- R9: The speaker output equals the counter output ANDed with the speaker data enable.
- R10: Status byte bit 5 carries the current counter output. All other status bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Counter clock-enable (about 1.19318 MHz rate) |
| ioWr | input | 1 | Register write strobe |
| ioAddr | input | 2 | Register address (0 divisor, 1 control) |
| ioData | input | 8 | Write data |
| spkOut | output | 1 | Speaker drive |
| statusByte | output | 8 | Readback, bit 5 = counter output |

## Verification
Both outputs are decoded without a register stage from state that is updated on the clock edge. A control write, or a cycle with the enable high, therefore shows its effect on the outputs immediately after that same edge, with zero extra cycles of latency. The bench drives each stimulus from one falling edge to the next and samples at that next falling edge, which falls between the edge that applied the stimulus and the edge that follows it. Tick counts are tracked one per enabled cycle, so the expected phase within the period is known exactly at every sample, including the 65536-tick wrap.

// File: rtl/spkr_pkg.sv
package spkr_pkg;
  // Strobes from the control unit to the counter datapath
  typedef struct packed {
    logic wrLow;   // capture low divisor byte
    logic wrHigh;  // complete divisor with high byte
    logic reload;  // gate rising edge: restart period
    logic step;    // advance counter one tick
  } toneStrobes_t;
endpackage

// File: rtl/spkr_ctrl.sv
module spkr_ctrl
  import spkr_pkg::*;
#(
  parameter int ADDR_W   = 2,
  parameter int DIV_ADDR = 0,
  parameter int CTL_ADDR = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              ioWr,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic [1:0]        ctlBits,
  output toneStrobes_t      strb,
  output logic              gateOn,
  output logic              dataOn
);
  logic lowNext;
  logic divWr;
  logic ctlWr;

  assign divWr = ioWr && (ioAddr == ADDR_W'(DIV_ADDR));
  assign ctlWr = ioWr && (ioAddr == ADDR_W'(CTL_ADDR));

  always_comb begin
    strb.wrLow  = divWr && lowNext;
    strb.wrHigh = divWr && !lowNext;
    strb.reload = ctlWr && ctlBits[0] && !gateOn;
    strb.step   = tickEn && gateOn && !strb.reload;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowNext <= 1'b1;
      gateOn  <= 1'b0;
      dataOn  <= 1'b0;
    end else begin
      if (divWr) lowNext <= !lowNext;
      if (ctlWr) begin
        gateOn <= ctlBits[0];
        dataOn <= ctlBits[1];
      end
    end
  end
endmodule

// File: rtl/spkr_datapath.sv
module spkr_datapath
  import spkr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  toneStrobes_t      strb,
  input  logic              gateOn,
  input  logic [DATA_W-1:0] ioData,
  output logic              toneOut
);
  localparam int DIV_W = 2 * DATA_W;
  localparam int CNT_W = DIV_W + 1;
  localparam logic [CNT_W-1:0] FULL = {1'b1, {DIV_W{1'b0}}};

  logic [DATA_W-1:0] lowByte;
  logic [CNT_W-1:0]  pendingDiv;
  logic [CNT_W-1:0]  activeDiv;
  logic [CNT_W-1:0]  cnt;
  logic [DIV_W-1:0]  newDiv;

  assign newDiv = {ioData, lowByte};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowByte    <= '0;
      pendingDiv <= FULL;
      activeDiv  <= FULL;
      cnt        <= FULL;
    end else begin
      if (strb.wrLow) lowByte <= ioData;
      if (strb.wrHigh)
        pendingDiv <= (newDiv == '0) ? FULL : {1'b0, newDiv};
      if (strb.reload || (strb.step && cnt == CNT_W'(1))) begin
        activeDiv <= pendingDiv;
        cnt       <= pendingDiv;
      end else if (strb.step) begin
        cnt <= cnt - CNT_W'(1);
      end
    end
  end

  // High while the remaining count is above half the period
  assign toneOut = !gateOn || (cnt > (activeDiv >> 1));
endmodule

// File: rtl/spkr_tone_top.sv
module spkr_tone_top #(
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = 2,
  parameter int STATUS_POS = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              ioWr,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic [DATA_W-1:0] ioData,
  output logic              spkOut,
  output logic [DATA_W-1:0] statusByte
);
  spkr_pkg::toneStrobes_t strb;
  logic gateOn;
  logic dataOn;
  logic toneOut;

  spkr_ctrl #(.ADDR_W(ADDR_W), .DIV_ADDR(0), .CTL_ADDR(1)) u_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .ioWr(ioWr), .ioAddr(ioAddr),
    .ctlBits(ioData[1:0]), .strb(strb), .gateOn(gateOn), .dataOn(dataOn)
  );

  spkr_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .gateOn(gateOn),
    .ioData(ioData), .toneOut(toneOut)
  );

  assign spkOut = toneOut && dataOn;

  always_comb begin
    statusByte = '0;
    statusByte[STATUS_POS] = toneOut;
  end
endmodule

// File: rtl/spkr_tone_chk.sv
module spkr_tone_chk (
  input logic       clk,
  input logic       rstN,
  input logic       tickEn,
  input logic       ioWr,
  input logic [1:0] ioAddr,
  input logic [1:0] ioData,
  input logic       spkOut,
  input logic [7:0] statusByte
);
  logic gateSh;
  logic dataSh;
  logic ctlW;

  assign ctlW = ioWr && (ioAddr == 2'd1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gateSh <= 1'b0;
      dataSh <= 1'b0;
    end else if (ctlW) begin
      gateSh <= ioData[0];
      dataSh <= ioData[1];
    end
  end

  // R5
  gate_low_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    !gateSh |-> statusByte[5]);

  // R6
  gate_rise_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctlW && ioData[0] && !gateSh) |=> statusByte[5]);

  // R8
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !ioWr) |=> $stable(statusByte));

  // R9
  spk_and_chk: assert property (@(posedge clk) disable iff (!rstN)
    spkOut |-> (statusByte[5] && dataSh));

  // R10
  status_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(statusByte & 8'hDF) == 0);
endmodule

bind spkr_tone_top spkr_tone_chk u_chk (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .ioWr(ioWr), .ioAddr(ioAddr),
  .ioData(ioData[1:0]), .spkOut(spkOut), .statusByte(statusByte)
);

// File: tb/sim_spkr_tone_top.sv
`timescale 1ns/1ps
module sim_spkr_tone_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic       ioWr = 1'b0;
  logic [1:0] ioAddr = '0;
  logic [7:0] ioData = '0;
  logic       spkOut;
  logic [7:0] statusByte;
  int nChk = 0;
  int nBad = 0;
  bit done = 0;

  always #4 clk = !clk;

  spkr_tone_top u0 (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .ioWr(ioWr), .ioAddr(ioAddr),
    .ioData(ioData), .spkOut(spkOut), .statusByte(statusByte)
  );

  // {dataBit, divisor}
  localparam logic [16:0] VEC [0:6] = '{
    {1'b1, 16'd1}, {1'b1, 16'd2}, {1'b0, 16'd3}, {1'b1, 16'd4},
    {1'b1, 16'd5}, {1'b0, 16'd7}, {1'b1, 16'd10}
  };

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    ioWr = 1'b1; ioAddr = a; ioData = d;
    @(negedge clk);
    ioWr = 1'b0;
  endtask

  task automatic wrDiv(logic [15:0] dv);
    wr(2'd0, dv[7:0]);
    wr(2'd0, dv[15:8]);
  endtask

  function automatic logic expHigh(int n, int k);
    return (k % n) < ((n + 1) / 2);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 status", statusByte, 8'h20);
    chk("R1 spk", {7'b0, spkOut}, 8'h00);

    // R4 R3 R9 R10 table walk
    for (int i = 0; i < 7; i++) begin
      logic d;
      int n;
      d = VEC[i][16];
      n = int'(VEC[i][15:0]);
      wrDiv(VEC[i][15:0]);
      wr(2'd1, {6'b0, d, 1'b0});
      chk("R5 gate low", statusByte, 8'h20);
      chk("R9 gate low", {7'b0, spkOut}, {7'b0, d});
      wr(2'd1, {6'b0, d, 1'b1});
      chk("R6 restart", statusByte, 8'h20);
      for (int k = 1; k <= 2 * n + 1; k++) begin
        tickEn = 1'b1;
        @(negedge clk);
        chk("R4 wave", statusByte, {2'b0, expHigh(n, k), 5'b0});
        chk("R9 and", {7'b0, spkOut}, {7'b0, expHigh(n, k) & d});
      end
      tickEn = 1'b0;
      wr(2'd1, 8'h00);
    end

    // R2 R9: toggle data bit with gate low
    wr(2'd1, 8'h02);
    chk("R2 data on", {7'b0, spkOut}, 8'h01);
    wr(2'd1, 8'h00);
    chk("R2 data off", {7'b0, spkOut}, 8'h00);
    // R2: writes to unused addresses ignored
    wr(2'd2, 8'hFF);
    wr(2'd3, 8'hFF);
    chk("R2 ignored spk", {7'b0, spkOut}, 8'h00);
    wr(2'd1, 8'h02);
    chk("R2 ignored gate", {7'b0, spkOut}, 8'h01);

    // R7 mid-period divisor change: N=4 then 6
    wrDiv(16'd4);
    wr(2'd1, 8'h03);
    tickEn = 1'b1; @(negedge clk); tickEn = 1'b0;
    chk("R7 p1", statusByte, 8'h20);
    wrDiv(16'd6);
    for (int k = 2; k <= 4; k++) begin
      tickEn = 1'b1; @(negedge clk);
      chk("R7 old period", statusByte, {2'b0, expHigh(4, k), 5'b0});
    end
    for (int k = 1; k <= 6; k++) begin
      tickEn = 1'b1; @(negedge clk);
      chk("R7 new period", statusByte, {2'b0, expHigh(6, k), 5'b0});
    end
    tickEn = 1'b0;

    // R8: no advance without enable (now at phase 0 of N=6)
    tickEn = 1'b1; @(negedge clk); @(negedge clk); @(negedge clk); tickEn = 1'b0;
    chk("R8 before", statusByte, 8'h00);
    repeat (5) @(negedge clk);
    chk("R8 held", statusByte, 8'h00);
    tickEn = 1'b1; @(negedge clk); @(negedge clk); @(negedge clk); tickEn = 1'b0;
    chk("R8 wrap", statusByte, 8'h20);

    // R5: ticks with gate low keep output high
    wr(2'd1, 8'h02);
    tickEn = 1'b1; repeat (4) @(negedge clk); tickEn = 1'b0;
    chk("R5 ticks gated", statusByte, 8'h20);

    // R3: zero divisor means 65536
    wrDiv(16'd0);
    wr(2'd1, 8'h03);
    tickEn = 1'b1;
    repeat (32767) @(negedge clk);
    chk("R3 65536 high", statusByte, 8'h20);
    @(negedge clk);
    chk("R3 65536 low", statusByte, 8'h00);
    repeat (32767) @(negedge clk);
    chk("R3 65536 end", statusByte, 8'h00);
    @(negedge clk);
    chk("R3 65536 wrap", statusByte, 8'h20);
    tickEn = 1'b0;

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end
endmodule